// File: doc/BRIEF.md
# Four-Mode SPI Byte Shifter

This block is the serial core of an SPI controller. Once it accepts a start, it generates the serial clock and shifts whole bytes in both directions at once on a single data lane. It runs until it has moved the commanded number of bytes, between 0 and 2047. Transmit bytes are drawn from a FIFO through a valid/ready pair. Each received byte is offered to a receive FIFO as a one-cycle valid pulse, and that side has no backpressure.

Several settings are sampled from the configuration inputs when a start is accepted and then held until the operation ends: clock polarity, clock phase, bit order, the 8-bit half-period divisor, and the separate transmit and receive enables. The surrounding controller handles chip select, register decoding and FIFO storage. It holds `start_i` only while `idle_o` is high.

Top module: `spi_shift_engine`

## Requirements
- R1: Inside a byte, every serial clock level lasts `half_per_i`+1 system clocks. Between two bytes the level lasts `half_per_i`+2 clocks, because of the fetch cycle. If the transmit side never stalls, `idle_o` stays low for N·(1+16·(H+1))+(H+1) clocks, where N is the byte count and H is the half-period value.
- R2: While idle, `sclk_o` rests at the level on `cpol_i`. With polarity 0 it rests low and the leading edge rises. With polarity 1 it rests high and the leading edge falls. After all 16 edges of a byte it is back at its resting level.
- R3: With phase 0, the first bit is on `mosi_o` before the first leading edge, the block samples `miso_i` on leading edges, and it changes `mosi_o` on trailing edges. With phase 1, it changes `mosi_o` on leading edges and samples on trailing edges.
- R4: With `msb_first_i`=1, bit 7 of each byte is sent and received first. With `msb_first_i`=0, bit 0 goes first.
- R5: An operation moves exactly N bytes, which is 8·N sample edges. A start with N=0 completes at once: `idle_o` never falls and no clock edge occurs.
- R6: `tx_ready_o` is high only during an operation with transmit enabled. One byte is taken per handshake. With transmit disabled, no handshake occurs.
- R7: With receive enabled, each completed byte appears on `rx_data_o` with a single-cycle `rx_valid_o` pulse. With receive disabled, `rx_valid_o` stays low.
- R8: The block accepts a start only while `idle_o` is high. A start during an operation has no effect on its length.
- R9: If transmit is enabled and no byte is valid at a byte boundary, the serial clock holds its resting level and no edge occurs until a byte arrives.
- R10: After reset, `idle_o` is 1, `tx_ready_o` and `rx_valid_o` are 0, and `sclk_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin an operation (used only while idle) |
| byte_cnt_i | input | 11 | Number of bytes to move |
| half_per_i | input | 8 | Serial clock half period minus one, in system clocks |
| cpol_i | input | 1 | Clock resting level |
| cpha_i | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| msb_first_i | input | 1 | Bit order select |
| tx_en_i | input | 1 | Take bytes from the transmit FIFO |
| rx_en_i | input | 1 | Push received bytes |
| idle_o | output | 1 | No operation in progress |
| tx_data_i | input | 8 | Transmit FIFO head byte |
| tx_valid_i | input | 1 | Transmit FIFO not empty |
| tx_ready_o | output | 1 | Engine takes the head byte this cycle |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Received byte push strobe |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
Some properties are checked on every cycle: the clock sits at its latched resting level whenever the engine waits for a transmit byte, ready and receive strobes appear only when their enables were latched, receive strobes never come back to back, a start during an operation leaves the remaining count untouched, and no half period lasts a single clock once the divisor is above zero. Other behaviour only the bench scenarios can show. A slave model checks that the bits line up with the right edge in each of the four modes and in both bit orders. The exact operation length in clocks, byte counts of zero and above, and the stall at an empty transmit FIFO are also covered by the scenarios.

// File: rtl/spi_eng_pkg.sv
// Shared definitions for the SPI byte shifter.
package spi_eng_pkg;
    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_SHIFT = 2'd2,
        ST_TAIL  = 2'd3
    } eng_state_e;
endpackage

// File: rtl/spi_eng_halfper.sv
// Half-period timer. Counts system clocks while run_i is high and emits
// tick_o on the last clock of each half period (limit_i+1 clocks long).
// Assumes limit_i is constant while run_i is high.
module spi_eng_halfper #(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [HALF_W-1:0] limit_i,
    output logic              tick_o
);
    logic [HALF_W-1:0] cnt_q;

    // Count up to limit_i, restart on wrap or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q == limit_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = run_i && (cnt_q == limit_i);

    AST_HALF_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && run_i && limit_i != '0) |=> !tick_o); // R1
endmodule

// File: rtl/spi_eng_shreg.sv
// Byte shift registers for both directions. The transmit register is
// loaded once per byte and shifted toward the output end. The receive
// register takes in one bit per sample strobe. Bit order is selected by
// msb_first_i. Assumes load_i and shift_i never coincide.
module spi_eng_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_data_i,
    input  logic         shift_i,
    input  logic         sample_i,
    input  logic         msb_first_i,
    input  logic         miso_i,
    output logic         mosi_o,
    output logic [W-1:0] rx_cur_o,
    output logic [W-1:0] rx_next_o
);
    logic [W-1:0] tx_q;
    logic [W-1:0] rx_q;

    // Transmit register: load a new byte or move one bit toward the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load_i) begin
            tx_q <= load_data_i;
        end else if (shift_i) begin
            tx_q <= msb_first_i ? {tx_q[W-2:0], 1'b0} : {1'b0, tx_q[W-1:1]};
        end
    end

    assign mosi_o    = msb_first_i ? tx_q[W-1] : tx_q[0];
    assign rx_next_o = msb_first_i ? {rx_q[W-2:0], miso_i} : {miso_i, rx_q[W-1:1]};
    assign rx_cur_o  = rx_q;

    // Receive register: take in one bit per sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (sample_i) begin
            rx_q <= rx_next_o;
        end
    end

    AST_LOAD_SHIFT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && shift_i)); // R3
endmodule

// File: rtl/spi_shift_engine.sv
// SPI byte shifter top. It latches the mode at start. For each byte it
// fetches a transmit byte, then runs 2*BYTE_W serial clock edges whose
// spacing comes from the half-period timer. After the last byte it holds
// one closing half period before returning to idle. Assumes the receive
// FIFO always accepts a push.
module spi_shift_engine #(
    parameter int HALF_W = 8,
    parameter int CNT_W  = 11,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  byte_cnt_i,
    input  logic [HALF_W-1:0] half_per_i,
    input  logic              cpol_i,
    input  logic              cpha_i,
    input  logic              msb_first_i,
    input  logic              tx_en_i,
    input  logic              rx_en_i,
    output logic              idle_o,
    input  logic [BYTE_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic              tx_ready_o,
    output logic [BYTE_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i
);
    import spi_eng_pkg::*;

    localparam int EDGES  = 2 * BYTE_W;
    localparam int EDGE_W = $clog2(EDGES);

    eng_state_e        state_q;
    logic [HALF_W-1:0] half_q;
    logic              cpol_q, cpha_q, msb_q, txe_q, rxe_q;
    logic [CNT_W-1:0]  left_q;
    logic [EDGE_W-1:0] edge_q;
    logic              sclk_q;
    logic [BYTE_W-1:0] rx_data_q;
    logic              rx_valid_q;

    logic              run, tick, edge_tick, leading, last_edge, take;
    logic              do_shift, do_sample;
    logic [BYTE_W-1:0] rx_cur, rx_next;

    assign run       = (state_q == ST_SHIFT) || (state_q == ST_TAIL);
    assign edge_tick = tick && (state_q == ST_SHIFT);
    assign leading   = ~edge_q[0];
    assign last_edge = (edge_q == EDGE_W'(EDGES - 1));
    assign take      = (state_q == ST_FETCH) && (!txe_q || tx_valid_i);
    assign do_shift  = edge_tick && (cpha_q ? (leading && edge_q != '0)
                                            : (!leading && !last_edge));
    assign do_sample = edge_tick && (cpha_q ? !leading : leading);

    spi_eng_halfper #(.HALF_W(HALF_W)) u_halfper (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .limit_i (half_q),
        .tick_o  (tick)
    );

    spi_eng_shreg #(.W(BYTE_W)) u_shreg (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (take),
        .load_data_i (txe_q ? tx_data_i : '0),
        .shift_i     (do_shift),
        .sample_i    (do_sample),
        .msb_first_i (msb_q),
        .miso_i      (miso_i),
        .mosi_o      (mosi_o),
        .rx_cur_o    (rx_cur),
        .rx_next_o   (rx_next)
    );

    // Sequencer: start acceptance, byte fetch, edge generation, closing half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            half_q  <= '0;
            cpol_q  <= 1'b0;
            cpha_q  <= 1'b0;
            msb_q   <= 1'b0;
            txe_q   <= 1'b0;
            rxe_q   <= 1'b0;
            left_q  <= '0;
            edge_q  <= '0;
            sclk_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    sclk_q <= cpol_i;
                    if (start_i && byte_cnt_i != '0) begin
                        half_q  <= half_per_i;
                        cpol_q  <= cpol_i;
                        cpha_q  <= cpha_i;
                        msb_q   <= msb_first_i;
                        txe_q   <= tx_en_i;
                        rxe_q   <= rx_en_i;
                        left_q  <= byte_cnt_i;
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (take) begin
                        edge_q  <= '0;
                        state_q <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (edge_tick) begin
                        sclk_q <= ~sclk_q;
                        edge_q <= edge_q + 1'b1;
                        if (last_edge) begin
                            left_q  <= left_q - 1'b1;
                            state_q <= (left_q == CNT_W'(1)) ? ST_TAIL : ST_FETCH;
                        end
                    end
                end
                default: begin
                    if (tick) begin
                        state_q <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    // Receive push: present the completed byte for one cycle after its last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid_q <= 1'b0;
            rx_data_q  <= '0;
        end else begin
            rx_valid_q <= edge_tick && last_edge && rxe_q;
            if (edge_tick && last_edge) begin
                rx_data_q <= cpha_q ? rx_next : rx_cur;
            end
        end
    end

    assign idle_o     = (state_q == ST_IDLE);
    assign tx_ready_o = (state_q == ST_FETCH) && txe_q;
    assign rx_valid_o = rx_valid_q;
    assign rx_data_o  = rx_data_q;
    assign sclk_o     = sclk_q;

    AST_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready_o |-> (txe_q && !idle_o)); // R6
    AST_RX_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> rxe_q); // R7
    AST_RX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o); // R7
    AST_STALL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH) |-> (sclk_o == cpol_q)); // R9
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_o && start_i && !edge_tick) |=> $stable(left_q)); // R8
    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_o && start_i && byte_cnt_i != '0) |=> !idle_o); // R8
    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_o && start_i && byte_cnt_i == '0) |=> idle_o); // R5
endmodule

// File: tb/spi_shift_engine_tb_top.sv
module spi_shift_engine_tb_top;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n, start, cpol, cpha, msb, txe, rxe;
    logic [10:0] byte_cnt;
    logic [7:0]  half;
    logic        idle, tx_ready, rx_valid, sclk, mosi, miso;
    logic [7:0]  tx_data, rx_data;
    logic        tx_avail;
    logic        slv_clr = 1'b0;
    int          cur_v = 0;

    spi_shift_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .byte_cnt_i(byte_cnt),
        .half_per_i(half), .cpol_i(cpol), .cpha_i(cpha), .msb_first_i(msb),
        .tx_en_i(txe), .rx_en_i(rxe), .idle_o(idle), .tx_data_i(tx_data),
        .tx_valid_i(tx_avail), .tx_ready_o(tx_ready), .rx_data_o(rx_data),
        .rx_valid_o(rx_valid), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso)
    );

    // Vector: [16:13] bytes, [12:5] half period, [4] cpol, [3] cpha, [2] msb, [1] txe, [0] rxe
    localparam logic [16:0] VECS [8] = '{
        {4'd3, 8'd0, 5'b00111}, {4'd2, 8'd1, 5'b01011},
        {4'd2, 8'd2, 5'b10111}, {4'd3, 8'd0, 5'b11011},
        {4'd1, 8'd3, 5'b00011}, {4'd2, 8'd0, 5'b11110},
        {4'd2, 8'd1, 5'b01101}, {4'd4, 8'd0, 5'b00111}
    };

    int n_checks = 0;
    int n_err    = 0;
    int cyc      = 0;

    function automatic logic [7:0] txb(int v, int i);
        return 8'h5A ^ 8'(v * 16 + i * 53);
    endfunction
    function automatic logic [7:0] mbyte(int v, int i);
        return 8'hC3 ^ 8'(v * 7 + i * 91);
    endfunction
    function automatic logic miso_bit(int v, int cnt, logic m);
        logic [7:0] b;
        int k;
        b = mbyte(v, cnt / 8);
        k = cnt % 8;
        return m ? b[7 - k] : b[k];
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Transmit FIFO model: advance on each handshake.
    int tx_idx = 0;
    always @(posedge clk) begin
        if (slv_clr) tx_idx <= 0;
        else if (tx_avail && tx_ready) tx_idx <= tx_idx + 1;
    end
    assign tx_data = txb(cur_v, tx_idx);

    // Slave model: tracks edges, captures mosi, drives miso, checks pushes.
    logic       sclk_prev = 1'b0;
    logic [7:0] s_sh = '0;
    int s_cnt = 0, s_mis = 0, r_cnt = 0, r_mis = 0, bad_iv = 0, last_ec = -1, n_edges = 0;
    assign miso = miso_bit(cur_v, s_cnt, msb);

    always @(negedge clk) begin
        if (slv_clr) begin
            s_cnt = 0; s_mis = 0; r_cnt = 0; r_mis = 0; bad_iv = 0;
            last_ec = -1; n_edges = 0; sclk_prev = sclk;
        end else begin
            if (sclk != sclk_prev) begin
                n_edges++;
                if (last_ec >= 0 && (cyc - last_ec) != int'(half) + 1 &&
                    (cyc - last_ec) != int'(half) + 2) bad_iv++;
                last_ec = cyc;
                if (sclk == (cpol ^ ~cpha)) begin
                    s_sh = msb ? {s_sh[6:0], mosi} : {mosi, s_sh[7:1]};
                    s_cnt++;
                    if (s_cnt % 8 == 0 && txe && s_sh != txb(cur_v, s_cnt / 8 - 1)) s_mis++;
                end
            end
            sclk_prev = sclk;
            if (rx_valid) begin
                if (rx_data != mbyte(cur_v, r_cnt)) r_mis++;
                r_cnt++;
            end
        end
    end

    task automatic setup(int v, int n, int h, logic p, logic a, logic m, logic te, logic re);
        @(negedge clk);
        cur_v = v; byte_cnt = 11'(n); half = 8'(h);
        cpol = p; cpha = a; msb = m; txe = te; rxe = re;
        repeat (2) @(posedge clk);
        slv_clr <= 1'b1;
        @(posedge clk);
        slv_clr <= 1'b0;
    endtask

    task automatic run_vec(int v, bit poke);
        int n, h, busy, exp_busy;
        n = int'(VECS[v][16:13]);
        h = int'(VECS[v][12:5]);
        setup(v, n, h, VECS[v][4], VECS[v][3], VECS[v][2], VECS[v][1], VECS[v][0]);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        busy = 0;
        while (!idle) begin
            busy++;
            if (poke && busy == 20) begin start = 1'b1; byte_cnt = 11'd7; end
            else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        exp_busy = n * (1 + 16 * (h + 1)) + h + 1;
        check(busy == exp_busy, poke ? "R8 busy start ignored" : "R1 R5 busy length", busy, exp_busy);
        check(bad_iv == 0, "R1 half period spacing", bad_iv, 0);
        check(s_cnt == 8 * n, "R5 sample edge count", s_cnt, 8 * n);
        check(s_mis == 0, "R3 R4 slave received bytes", s_mis, 0);
        check(r_mis == 0, "R3 R4 pushed bytes", r_mis, 0);
        check(r_cnt == (rxe ? n : 0), "R7 push count", r_cnt, rxe ? n : 0);
        check(tx_idx == (txe ? n : 0), "R6 handshake count", tx_idx, txe ? n : 0);
        @(negedge clk);
        check(sclk == cpol, "R2 resting level", sclk, cpol);
    endtask

    task automatic run_all();
        int bad;
        rst_n = 1'b0; start = 1'b0; byte_cnt = '0; half = '0;
        cpol = 1'b0; cpha = 1'b0; msb = 1'b0; txe = 1'b1; rxe = 1'b1; tx_avail = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        check(idle == 1'b1, "R10 idle", idle, 1);
        check(tx_ready == 1'b0, "R10 tx_ready", tx_ready, 0);
        check(rx_valid == 1'b0, "R10 rx_valid", rx_valid, 0);
        check(sclk == 1'b0, "R10 sclk", sclk, 0);
        rst_n = 1'b1;

        for (int v = 0; v < 8; v++) run_vec(v, v == 7);

        // R5: zero count completes at once
        setup(8, 0, 1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        bad = 0;
        for (int i = 0; i < 10; i++) begin
            if (!idle) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R5 zero count idle", bad, 0);
        check(n_edges == 0, "R5 zero count no edges", n_edges, 0);

        // R9: stall with empty transmit FIFO
        setup(9, 2, 1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        tx_avail = 1'b0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (30) @(negedge clk);
        check(idle == 1'b0, "R9 stall busy", idle, 0);
        check(sclk == 1'b1, "R9 stall level", sclk, 1);
        check(n_edges == 0, "R9 stall no edges", n_edges, 0);
        tx_avail = 1'b1;
        while (!idle) @(negedge clk);
        check(s_cnt == 16 && s_mis == 0, "R9 bytes after stall", s_mis, 0);
        check(r_cnt == 2 && r_mis == 0, "R9 R7 pushes after stall", r_cnt, 2);
    endtask

    initial begin
        bit wd = 1'b0;
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        disable fork;
        if (wd) check(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule